// File: doc/BRIEF.md
# Video Memory Pixel Port with Frame Copy

This block stands between a host processor bus and a 16-bit-wide external video SRAM. The host never addresses that memory itself. It uses four small registers. One register loads a word pointer. A second register takes a 24-bit pixel, which the block stores at the pointer. The pointer then moves on by itself, so a run of pixels needs no address updates. Each pixel takes two SRAM words, upper colour half first. Only the low 12 bits of each word carry data; the top four bits are always zero.

The display is never refreshed on its own. When the host sets the start bit in the control register, the block sends a one-cycle start-of-frame pulse to the LCD driver. It then reads the stored frame from SRAM address 0 upward and writes each word's low 12 bits into the driver's frame memory over a parallel strobe interface. A status bit shows the copy is running. Pixel writes issued during that time are held off with a ready signal, not dropped. Once the copy ends, the display outputs stay quiet until the next command.

Top module: `vpp_pixel_port`

## Requirements
- R1: After reset the SRAM write and output enables (active low) are high, the LCD strobe and start-of-frame pulse are low, status bit 0 reads 0 and the pointer reads 0.
- R2: A write to register 0 loads the 20-bit word pointer with any value. A read of register 0 returns the pointer in bits 19:0.
- R3: A write to register 1 stores pixel bits 23:12 in the SRAM word at the pointer and bits 11:0 in the following word. SRAM data bits 15:12 are written as zero.
- R4: Each accepted pixel write advances the pointer by two words.
- R5: The pointer steps from the last frame word (FRAME_WORDS-1) to 0. This also applies between the two halves of one pixel.
- R6: Writing register 2 with bit 0 set starts a copy, and register 3 bit 0 then reads 1 until the copy ends. Writing register 2 with bit 0 clear starts nothing.
- R7: A copy raises the start-of-frame output for one cycle. It then gives exactly FRAME_WORDS strobes, carrying the low 12 bits of SRAM words 0, 1, 2 and so on in address order.
- R8: The LCD strobe lasts one cycle. The LCD data is unchanged in the cycle before and the cycle after each strobe.
- R9: Outside a copy the LCD strobe and start-of-frame outputs stay low.
- R10: A pixel write issued during a copy sees host_ready low until the copy ends. It is then carried out in full.
- R11: A copy request made while a copy is running is ignored. The running copy gives exactly FRAME_WORDS strobes and no second frame follows.
- R12: The SRAM write and output enables are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host transfer request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register select: 0 pointer, 1 pixel, 2 control, 3 status |
| host_wdata | input | 24 | Host write data |
| host_rdata | output | 24 | Register read data for host_addr |
| host_ready | output | 1 | Transfer accepted on this edge when high |
| sram_addr | output | 20 | Video SRAM word address |
| sram_wdata | output | 16 | Video SRAM write data |
| sram_rdata | input | 16 | Video SRAM read data, valid one cycle after output enable |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| lcd_data | output | 12 | Pixel word to the LCD driver |
| lcd_wr | output | 1 | LCD write strobe, active high |
| lcd_sof | output | 1 | One-cycle start-of-frame pulse to the LCD driver |

## Verification
If the pointer goes wrong, the next pixel lands at a wrong SRAM address. Readback of register 0 exposes it right after the write, and so does the following frame copy. If the copy sequencer goes wrong, the result appears on the LCD pins during that copy: a word out of order, a missing or extra strobe, data that moves around a strobe, or a busy flag that clears too early or too late. An error in the stall logic shows up in the copied frame and the SRAM contents, as a lost pixel or as one written into the frame while it is being read out.

// File: rtl/vpp_pkg.sv
package vpp_pkg;

   typedef enum logic [1:0] {
      REG_PTR  = 2'd0,
      REG_PIX  = 2'd1,
      REG_CTRL = 2'd2,
      REG_STAT = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      CP_IDLE,
      CP_SOF,
      CP_RD,
      CP_LAT,
      CP_SET,
      CP_STB
   } copy_st_e;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_FIRST,
      WS_SECOND
   } wr_st_e;

endpackage

// File: rtl/vpp_host_regs.sv
module vpp_host_regs
   import vpp_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int PIX_W  = 24
) (
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [1:0]        host_addr,
   input  logic [PIX_W-1:0]  host_wdata,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              wr_busy,
   input  logic              copy_busy,
   output logic [PIX_W-1:0]  host_rdata,
   output logic              host_ready,
   output logic              load_en,
   output logic              pix_en,
   output logic              copy_start
);

   localparam int PAD_W = PIX_W - ADDR_W;

   reg_sel_e sel_reg;
   logic     is_write;
   logic     pix_blocked;

   assign sel_reg     = reg_sel_e'(host_addr);
   assign is_write    = host_sel && host_wr;
   assign pix_blocked = (sel_reg == REG_PIX) && copy_busy;

   // the two-word write engine holds every transfer; the copy only holds pixels
   assign host_ready = !wr_busy && !(is_write && pix_blocked);

   assign load_en    = is_write && host_ready && (sel_reg == REG_PTR);
   assign pix_en     = is_write && host_ready && (sel_reg == REG_PIX);
   assign copy_start = is_write && host_ready && (sel_reg == REG_CTRL) && host_wdata[0];

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb begin
            host_rdata = '0;
            case (sel_reg)
               REG_PTR:  host_rdata = {{PAD_W{1'b0}}, ptr};
               REG_STAT: host_rdata = {{(PIX_W-1){1'b0}}, copy_busy};
               default:  host_rdata = '0;
            endcase
         end
      end else begin : g_nopad
         always_comb begin
            host_rdata = '0;
            case (sel_reg)
               REG_PTR:  host_rdata = ptr[PIX_W-1:0];
               REG_STAT: host_rdata = {{(PIX_W-1){1'b0}}, copy_busy};
               default:  host_rdata = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/vpp_write_seq.sv
module vpp_write_seq
   import vpp_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int PIX_W       = 24,
   parameter int SRAM_W      = 16,
   parameter int HALF_W      = 12,
   parameter int FRAME_WORDS = 768000,
   parameter bit HI_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              pix_en,
   input  logic [PIX_W-1:0]  pix_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              busy,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [SRAM_W-1:0] wdata
);

   localparam int              PAD_W = SRAM_W - HALF_W;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_WORDS - 1);

   wr_st_e            st;
   logic [HALF_W-1:0] first_half, second_half;
   logic [HALF_W-1:0] first_q, second_q;
   logic [HALF_W-1:0] cur_half;
   logic [ADDR_W-1:0] ptr_next;

   generate
      if (HI_FIRST) begin : g_hi_first
         assign first_half  = pix_data[PIX_W-1:HALF_W];
         assign second_half = pix_data[HALF_W-1:0];
      end else begin : g_lo_first
         assign first_half  = pix_data[HALF_W-1:0];
         assign second_half = pix_data[PIX_W-1:HALF_W];
      end
   endgenerate

   assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= WS_IDLE;
         ptr      <= '0;
         first_q  <= '0;
         second_q <= '0;
      end else begin
         case (st)
            WS_IDLE: begin
               if (load_en) ptr <= load_val;
               if (pix_en) begin
                  first_q  <= first_half;
                  second_q <= second_half;
                  st       <= WS_FIRST;
               end
            end
            WS_FIRST: begin
               ptr <= ptr_next;
               st  <= WS_SECOND;
            end
            WS_SECOND: begin
               ptr <= ptr_next;
               st  <= WS_IDLE;
            end
            default: st <= WS_IDLE;
         endcase
      end
   end

   assign busy     = (st != WS_IDLE);
   assign we       = busy;
   assign waddr    = ptr;
   assign cur_half = (st == WS_FIRST) ? first_q : second_q;

   generate
      if (PAD_W > 0) begin : g_wpad
         assign wdata = {{PAD_W{1'b0}}, cur_half};
      end else begin : g_wnopad
         assign wdata = cur_half;
      end
   endgenerate

endmodule

// File: rtl/vpp_copy_seq.sv
module vpp_copy_seq
   import vpp_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int SRAM_W      = 16,
   parameter int LCD_W       = 12,
   parameter int FRAME_WORDS = 768000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SRAM_W-1:0] sram_rdata,
   output logic              busy,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [LCD_W-1:0]  lcd_data,
   output logic              lcd_wr,
   output logic              lcd_sof
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_WORDS - 1);

   copy_st_e          st;
   logic [ADDR_W-1:0] cnt;
   logic [LCD_W-1:0]  data_q;

   // word cadence: read, latch, setup, strobe; the next read doubles as hold
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= CP_IDLE;
         cnt    <= '0;
         data_q <= '0;
      end else begin
         case (st)
            CP_IDLE: begin
               if (start) begin
                  cnt <= '0;
                  st  <= CP_SOF;
               end
            end
            CP_SOF: st <= CP_RD;
            CP_RD:  st <= CP_LAT;
            CP_LAT: begin
               data_q <= sram_rdata[LCD_W-1:0];
               st     <= CP_SET;
            end
            CP_SET: st <= CP_STB;
            CP_STB: begin
               if (cnt == LAST) begin
                  st <= CP_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
                  st  <= CP_RD;
               end
            end
            default: st <= CP_IDLE;
         endcase
      end
   end

   assign busy     = (st != CP_IDLE);
   assign rd_en    = (st == CP_RD);
   assign rd_addr  = cnt;
   assign lcd_data = data_q;
   assign lcd_wr   = (st == CP_STB);
   assign lcd_sof  = (st == CP_SOF);

endmodule

// File: rtl/vpp_sram_mux.sv
module vpp_sram_mux #(
   parameter int ADDR_W = 20,
   parameter int SRAM_W = 16
) (
   input  logic              w_we,
   input  logic [ADDR_W-1:0] w_addr,
   input  logic [SRAM_W-1:0] w_data,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] r_addr,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [SRAM_W-1:0] sram_wdata,
   output logic              sram_we_n,
   output logic              sram_oe_n
);

   // a read takes the port; the host stall keeps writes away during copies
   assign sram_addr  = r_en ? r_addr : w_addr;
   assign sram_wdata = w_data;
   assign sram_oe_n  = !r_en;
   assign sram_we_n  = !(w_we && !r_en);

endmodule

// File: rtl/vpp_pixel_port.sv
module vpp_pixel_port #(
   parameter int ADDR_W      = 20,
   parameter int PIX_W       = 24,
   parameter int SRAM_W      = 16,
   parameter int LCD_W       = 12,
   parameter int FRAME_WORDS = 768000,
   parameter bit HI_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [1:0]        host_addr,
   input  logic [PIX_W-1:0]  host_wdata,
   output logic [PIX_W-1:0]  host_rdata,
   output logic              host_ready,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [SRAM_W-1:0] sram_wdata,
   input  logic [SRAM_W-1:0] sram_rdata,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [LCD_W-1:0]  lcd_data,
   output logic              lcd_wr,
   output logic              lcd_sof
);

   localparam int HALF_W = PIX_W / 2;

   if (HALF_W * 2 != PIX_W) begin : g_chk_pix
      $error("PIX_W must be even");
   end
   if (HALF_W != LCD_W) begin : g_chk_lcd
      $error("half pixel must match LCD width");
   end
   if (LCD_W > SRAM_W) begin : g_chk_sram
      $error("LCD word wider than SRAM word");
   end
   if (ADDR_W > PIX_W) begin : g_chk_ptr
      $error("pointer must fit the host data bus");
   end
   if (FRAME_WORDS < 2 || longint'(FRAME_WORDS) > (longint'(1) << ADDR_W)) begin : g_chk_frame
      $error("frame size does not fit the address range");
   end

   logic [ADDR_W-1:0] ptr;
   logic              wr_busy, copy_busy;
   logic              load_en, pix_en, copy_start;
   logic              w_we, r_en;
   logic [ADDR_W-1:0] w_addr, r_addr;
   logic [SRAM_W-1:0] w_data;

   vpp_host_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_regs (
      .host_sel   (host_sel),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .ptr        (ptr),
      .wr_busy    (wr_busy),
      .copy_busy  (copy_busy),
      .host_rdata (host_rdata),
      .host_ready (host_ready),
      .load_en    (load_en),
      .pix_en     (pix_en),
      .copy_start (copy_start)
   );

   vpp_write_seq #(
      .ADDR_W(ADDR_W), .PIX_W(PIX_W), .SRAM_W(SRAM_W), .HALF_W(HALF_W),
      .FRAME_WORDS(FRAME_WORDS), .HI_FIRST(HI_FIRST)
   ) u_wseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .load_val (host_wdata[ADDR_W-1:0]),
      .pix_en   (pix_en),
      .pix_data (host_wdata),
      .ptr      (ptr),
      .busy     (wr_busy),
      .we       (w_we),
      .waddr    (w_addr),
      .wdata    (w_data)
   );

   vpp_copy_seq #(
      .ADDR_W(ADDR_W), .SRAM_W(SRAM_W), .LCD_W(LCD_W), .FRAME_WORDS(FRAME_WORDS)
   ) u_copy (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (copy_start),
      .sram_rdata (sram_rdata),
      .busy       (copy_busy),
      .rd_en      (r_en),
      .rd_addr    (r_addr),
      .lcd_data   (lcd_data),
      .lcd_wr     (lcd_wr),
      .lcd_sof    (lcd_sof)
   );

   vpp_sram_mux #(.ADDR_W(ADDR_W), .SRAM_W(SRAM_W)) u_mux (
      .w_we       (w_we),
      .w_addr     (w_addr),
      .w_data     (w_data),
      .r_en       (r_en),
      .r_addr     (r_addr),
      .sram_addr  (sram_addr),
      .sram_wdata (sram_wdata),
      .sram_we_n  (sram_we_n),
      .sram_oe_n  (sram_oe_n)
   );

endmodule

// File: rtl/vpp_port_checker.sv
module vpp_port_checker #(
   parameter int LCD_W  = 12,
   parameter int SRAM_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_sel,
   input logic              host_wr,
   input logic [1:0]        host_addr,
   input logic              host_ready,
   input logic              copy_busy,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic [SRAM_W-1:0] sram_wdata,
   input logic [LCD_W-1:0]  lcd_data,
   input logic              lcd_wr,
   input logic              lcd_sof
);

   a_r12_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_we_n && !sram_oe_n));

   a_r3_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_wdata[SRAM_W-1:LCD_W] == '0));

   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_wr |=> !lcd_wr);

   a_r8_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_wr) |-> $stable(lcd_data));

   a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_wr |=> $stable(lcd_data));

   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_busy |-> (!lcd_wr && !lcd_sof));

   a_r10_pixel_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_wr && host_addr == 2'd1 && copy_busy) |-> !host_ready);

   a_r7_sof_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_sof |-> !lcd_wr);

endmodule

bind vpp_pixel_port vpp_port_checker #(.LCD_W(LCD_W), .SRAM_W(SRAM_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_sel   (host_sel),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_ready (host_ready),
   .copy_busy  (copy_busy),
   .sram_we_n  (sram_we_n),
   .sram_oe_n  (sram_oe_n),
   .sram_wdata (sram_wdata),
   .lcd_data   (lcd_data),
   .lcd_wr     (lcd_wr),
   .lcd_sof    (lcd_sof)
);

// File: tb/tb_vpp_pixel_port.sv
`timescale 1ns/1ps
module tb_vpp_pixel_port;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_wr = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [23:0] host_wdata = '0;
   logic [23:0] host_rdata;
   logic        host_ready;
   logic [19:0] sram_addr;
   logic [15:0] sram_wdata;
   logic [15:0] sram_rdata = '0;
   logic        sram_we_n, sram_oe_n;
   logic [11:0] lcd_data;
   logic        lcd_wr, lcd_sof;

   always #2.5 clk = ~clk;

   vpp_pixel_port #(.FRAME_WORDS(N)) dut (.*);

   // external SRAM model
   logic [15:0] mem [0:N-1];
   always @(posedge clk) begin
      if (!sram_we_n && sram_addr < 20'(N)) mem[sram_addr] <= sram_wdata;
      if (!sram_oe_n && sram_addr < 20'(N)) sram_rdata <= mem[sram_addr];
   end

   int n_cmp = 0, n_bad = 0;
   int strobes = 0, sofs = 0;
   logic [15:0] exp_mem [0:N-1];
   int exp_ptr = 0;
   logic [11:0] lcd_q [$];
   logic [11:0] prev_data = '0, held = '0;
   bit hold_chk = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor on the LCD side
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_chk) begin
            chk(lcd_data == held, "R8 hold after strobe", 32'(lcd_data), 32'(held));
            hold_chk = 0;
         end
         if (lcd_wr) begin
            strobes++;
            chk(lcd_data == prev_data, "R8 setup before strobe", 32'(lcd_data), 32'(prev_data));
            if (lcd_q.size() == 0) begin
               chk(1'b0, "R9 unexpected strobe", 32'(lcd_data), 32'h0);
            end else begin
               logic [11:0] e;
               e = lcd_q.pop_front();
               chk(lcd_data == e, "R7 copied word", 32'(lcd_data), 32'(e));
            end
            held = lcd_data;
            hold_chk = 1;
         end
         if (lcd_sof) sofs++;
         if (!sram_we_n)
            chk(sram_wdata[15:12] == 4'h0, "R3 top bits zero", 32'(sram_wdata), 32'(sram_wdata & 16'h0fff));
         prev_data = lcd_data;
      end
   end

   task automatic host_write(input logic [1:0] a, input logic [23:0] d, output int stalls);
      stalls = 0;
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      #0.1;
      while (!host_ready) begin
         stalls++;
         @(negedge clk);
         #0.1;
      end
      @(posedge clk);
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] a, output logic [23:0] d);
      @(negedge clk);
      host_addr = a;
      #0.1;
      d = host_rdata;
   endtask

   function automatic int inc(input int p);
      return (p == N-1) ? 0 : p + 1;
   endfunction

   task automatic exp_pixel(input logic [23:0] px);
      exp_mem[exp_ptr] = {4'h0, px[23:12]};
      exp_ptr = inc(exp_ptr);
      exp_mem[exp_ptr] = {4'h0, px[11:0]};
      exp_ptr = inc(exp_ptr);
   endtask

   task automatic cmp_mem(input string tag);
      int diffs = 0;
      for (int i = 0; i < N; i++) if (mem[i] !== exp_mem[i]) diffs++;
      chk(diffs == 0, tag, 32'(diffs), 32'h0);
   endtask

   task automatic push_frame();
      for (int i = 0; i < N; i++) lcd_q.push_back(exp_mem[i][11:0]);
   endtask

   task automatic wait_idle(output int cycles);
      logic [23:0] s;
      cycles = 0;
      do begin
         host_read(2'd3, s);
         cycles++;
      end while (s[0] && cycles < 500);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [23:0] r;
      int st, cyc, s0, f0;
      for (int i = 0; i < N; i++) begin
         mem[i] = 16'(16'h0100 + i);
         exp_mem[i] = 16'(16'h0100 + i);
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(sram_we_n === 1'b1 && sram_oe_n === 1'b1, "R1 sram enables idle", {30'h0, sram_we_n, sram_oe_n}, 32'h3);
      chk(lcd_wr === 1'b0 && lcd_sof === 1'b0, "R1 lcd outputs idle", {30'h0, lcd_wr, lcd_sof}, 32'h0);
      rst_n = 1'b1;
      host_read(2'd3, r);
      chk(r[0] == 1'b0, "R1 status idle", 32'(r), 32'h0);
      host_read(2'd0, r);
      chk(r == 24'h0, "R1 pointer zero", 32'(r), 32'h0);

      // R2 arbitrary pointer load
      host_write(2'd0, 24'h0ABCDE, st);
      host_read(2'd0, r);
      chk(r == 24'h0ABCDE, "R2 pointer load", 32'(r), 32'h0ABCDE);
      host_write(2'd0, 24'd3, st);
      exp_ptr = 3;
      host_read(2'd0, r);
      chk(r == 24'd3, "R2 pointer reload", 32'(r), 32'd3);

      // R3 R4 sequential pixels
      host_write(2'd1, 24'h123456, st); exp_pixel(24'h123456);
      host_write(2'd1, 24'hFEDCBA, st); exp_pixel(24'hFEDCBA);
      repeat (2) @(negedge clk);
      cmp_mem("R3 pixel halves stored");
      host_read(2'd0, r);
      chk(r == 24'd7, "R4 pointer advanced by four", 32'(r), 32'd7);

      // R5 wrap inside a pixel
      host_write(2'd0, 24'(N-1), st); exp_ptr = N-1;
      host_write(2'd1, 24'hA5A5A5, st); exp_pixel(24'hA5A5A5);
      repeat (2) @(negedge clk);
      cmp_mem("R5 wrap split pixel");
      host_read(2'd0, r);
      chk(r == 24'd1, "R5 pointer wrapped", 32'(r), 32'd1);

      // R9 nothing on the display so far; R6 clear bit starts nothing
      host_write(2'd2, 24'h000000, st);
      repeat (10) @(negedge clk);
      host_read(2'd3, r);
      chk(r[0] == 1'b0, "R6 clear bit no copy", 32'(r), 32'h0);
      chk(strobes == 0 && sofs == 0, "R9 display quiet", 32'(strobes + sofs), 32'h0);

      // R6 R7 full copy
      push_frame();
      host_write(2'd2, 24'h000001, st);
      host_read(2'd3, r);
      chk(r[0] == 1'b1, "R6 busy during copy", 32'(r), 32'h1);
      wait_idle(cyc);
      repeat (2) @(negedge clk);
      chk(strobes == N, "R7 strobe count", 32'(strobes), 32'(N));
      chk(sofs == 1, "R7 one start pulse", 32'(sofs), 32'h1);
      chk(lcd_q.size() == 0, "R7 all words sent", 32'(lcd_q.size()), 32'h0);

      // R10 R11 stalled pixel and ignored second request
      s0 = strobes; f0 = sofs;
      push_frame();
      host_write(2'd2, 24'h000001, st);
      host_write(2'd2, 24'h000001, st);
      host_write(2'd1, 24'h0F1E2D, st);
      chk(st > 0, "R10 pixel stalled", 32'(st), 32'h1);
      chk(strobes - s0 == N, "R10 accepted only after copy", 32'(strobes - s0), 32'(N));
      exp_pixel(24'h0F1E2D);
      repeat (2) @(negedge clk);
      cmp_mem("R10 stalled pixel stored");
      repeat (20) @(negedge clk);
      host_read(2'd3, r);
      chk(r[0] == 1'b0, "R11 no second copy", 32'(r), 32'h0);
      chk(strobes - s0 == N && sofs - f0 == 1, "R11 single frame", 32'(strobes - s0), 32'(N));

      // R7 copy carries the updated contents
      push_frame();
      host_write(2'd2, 24'h000001, st);
      wait_idle(cyc);
      repeat (2) @(negedge clk);
      chk(lcd_q.size() == 0, "R7 updated frame sent", 32'(lcd_q.size()), 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule